// File: doc/BRIEF.md
# Bit-Field Extract/Insert Unit

This unit is a 64-bit datapath that pulls a contiguous bit field out of a source word, or merges a field into a destination word. A 3-bit operation code selects one of eight variants: four extracts and four inserts, each in a 32-bit form and three 64-bit forms. Two 5-bit position fields describe the field. The variant decides how they are read: as a width less one or as a top bit, and whether 32 is added to the top position, the bottom position, or both. With this bias, two 5-bit fields reach every bit position from 0 to 63.

An extract shifts the selected field of `in_src` down to bit 0 and clears the bits above it. An insert keeps `in_dst` everywhere except the field, and fills the field with the low-order bits of `in_src`. The 32-bit variants then copy bit 31 of the result into bits 63:32.

A position pair that is out of range for its variant returns `in_dst` unchanged and raises an error flag. A pair is out of range when the top bit is below the bottom bit, or when the top bit lies past the word size of the variant. The result is registered. The unit accepts a new operation every cycle and returns its result one cycle later.

Top module: `bfu_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. A synchronous `rst` clears `out_valid`, `out_data` and `out_err`, even when `in_valid` is high during reset.
- R2: Op 0, the 32-bit extract. Width = hi_fld+1 and bottom = lo_fld. The field is legal when bottom+width ≤ 32. The result is `in_src[bottom +: width]` zero-extended, and then bit 31 is copied into bits 63:32.
- R3: Op 1, the 64-bit extract. Width = hi_fld+1 and bottom = lo_fld. The result is the field zero-extended. This op never reports an error.
- R4: Op 2, the 64-bit wide extract. Width = hi_fld+33 and bottom = lo_fld. The field is legal when bottom+width ≤ 64. The result is the field zero-extended.
- R5: Op 3, the 64-bit upper extract. Width = hi_fld+1 and bottom = lo_fld+32. The field is legal when bottom+width ≤ 64. The result is the field zero-extended.
- R6: Op 4, the 32-bit insert. Top = hi_fld and bottom = lo_fld. The field is legal when top ≥ bottom. Bits [top:bottom] take the low bits of `in_src`, the other bits keep `in_dst`, and then bit 31 is copied into bits 63:32.
- R7: Op 5, the 64-bit insert. Top = hi_fld and bottom = lo_fld. The field is legal when top ≥ bottom. The result is the merge without sign extension.
- R8: Op 6, the 64-bit wide insert. Top = hi_fld+32 and bottom = lo_fld. This op never reports an error. The result is the merge without sign extension.
- R9: Op 7, the 64-bit upper insert. Top = hi_fld+32 and bottom = lo_fld+32. The field is legal when top ≥ bottom. The result is the merge without sign extension.
- R10: For an out-of-range pair, `out_err` = 1 and `out_data` = `in_dst`. For a legal pair, `out_err` = 0.
- R11: A field width of 64 uses an all-ones mask. With op 2, hi_fld=31 and lo_fld=0, the result is `in_src`. With op 6, hi_fld=31 and lo_fld=0, the result is also `in_src`.
- R12: While `in_valid` is low, `out_data` and `out_err` hold their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Variant select, 0..7 as in R2–R9 |
| in_hi_fld | input | 5 | Width-less-one or top-bit field (biased per variant) |
| in_lo_fld | input | 5 | Bottom-bit field (biased per variant) |
| in_src | input | 64 | Source operand supplying field bits |
| in_dst | input | 64 | Merge operand for inserts, fallback for errors |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Registered result |
| out_err | output | 1 | Position pair was out of range |

## Verification
Most internal faults appear at the ports in the cycle right after the operation, because only one register stage lies between input and output. A wrong bias or a wrong range test shows up in one of three ways: a field starts at the wrong bit, `out_err` has the wrong value, or `in_dst` passes through where a merge was expected. A mask fault at the width extremes shows only at a full-width or single-bit field, so every legal and illegal position pair is swept for each variant. A fault in sign extension shows up only when bit 31 of the result is set.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int FLD_W = $clog2(HALF);
    localparam int SH_W  = $clog2(XLEN);
    localparam int POS_W = SH_W + 2;

    // Bit 2 of the code separates inserts from extracts.
    typedef enum logic [2:0] {
        OP_EXTW = 3'd0,
        OP_EXTD = 3'd1,
        OP_EXTM = 3'd2,
        OP_EXTU = 3'd3,
        OP_INSW = 3'd4,
        OP_INSD = 3'd5,
        OP_INSM = 3'd6,
        OP_INSU = 3'd7
    } bf_op_e;

    typedef struct packed {
        logic [POS_W-1:0] lo;
        logic [POS_W-1:0] hi;
        logic             narrow;
        logic             is_ins;
        logic             bad;
    } bf_span_t;

    function automatic logic is_insert(bf_op_e op);
        return op[2];
    endfunction

    function automatic logic [XLEN-1:0] sext_half(logic [XLEN-1:0] v);
        return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
    endfunction
endpackage

// File: rtl/bfu_posdec.sv
module bfu_posdec
    import bfu_pkg::*;
(
    input  bf_op_e           op,
    input  logic [FLD_W-1:0] hi_fld,
    input  logic [FLD_W-1:0] lo_fld,
    output bf_span_t         span
);
    logic [POS_W-1:0] a, b, bias, lim;

    always_comb begin
        a    = POS_W'(hi_fld);
        b    = POS_W'(lo_fld);
        bias = POS_W'(HALF);
        span.lo     = b;
        span.hi     = a;
        span.narrow = 1'b0;
        span.is_ins = is_insert(op);
        unique case (op)
            OP_EXTW: begin span.hi = b + a; span.narrow = 1'b1; end
            OP_EXTD: span.hi = b + a;
            OP_EXTM: span.hi = b + a + bias;
            OP_EXTU: begin span.lo = b + bias; span.hi = b + a + bias; end
            OP_INSW: span.narrow = 1'b1;
            OP_INSD: span.hi = a;
            OP_INSM: span.hi = a + bias;
            OP_INSU: begin span.lo = b + bias; span.hi = a + bias; end
            default: span.hi = a;
        endcase
        lim      = span.narrow ? POS_W'(HALF) : POS_W'(XLEN);
        span.bad = (span.hi < span.lo) || (span.hi >= lim);
    end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge
    import bfu_pkg::*;
(
    input  bf_span_t        span,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    output logic [XLEN-1:0] res,
    output logic            err
);
    logic [XLEN-1:0] fmask, ext_raw, ins_raw, pick;
    logic [SH_W-1:0] sh;

    // One comparator pair per bit builds the field mask, so width 64 is simply all ones.
    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        assign fmask[i] = (POS_W'(i) >= span.lo) && (POS_W'(i) <= span.hi);
    end

    assign sh = span.lo[SH_W-1:0];

    always_comb begin
        ext_raw = (src & fmask) >> sh;
        ins_raw = (dst & ~fmask) | ((src << sh) & fmask);
        pick    = span.is_ins ? ins_raw : ext_raw;
        if (span.bad)
            res = dst;
        else if (span.narrow)
            res = sext_half(pick);
        else
            res = pick;
        err = span.bad;
    end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
    import bfu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [FLD_W-1:0] in_hi_fld,
    input  logic [FLD_W-1:0] in_lo_fld,
    input  logic [XLEN-1:0]  in_src,
    input  logic [XLEN-1:0]  in_dst,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_data,
    output logic             out_err
);
    bf_span_t        span;
    logic [XLEN-1:0] nxt_data;
    logic            nxt_err;

    bfu_posdec u_posdec (
        .op     (bf_op_e'(in_op)),
        .hi_fld (in_hi_fld),
        .lo_fld (in_lo_fld),
        .span   (span)
    );

    bfu_merge u_merge (
        .span (span),
        .src  (in_src),
        .dst  (in_dst),
        .res  (nxt_data),
        .err  (nxt_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= nxt_data;
                out_err  <= nxt_err;
            end
        end
    end
endmodule

// File: rtl/bfu_chk.sv
module bfu_chk
    import bfu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic [FLD_W-1:0] in_hi_fld,
    input logic [FLD_W-1:0] in_lo_fld,
    input logic [XLEN-1:0]  in_src,
    input logic [XLEN-1:0]  in_dst,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_data,
    input logic             out_err
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    err_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_err || out_data == $past(in_dst)));
    // R3
    dext_noerr_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd1) |=> !out_err);
    // R8
    dinsm_noerr_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd6) |=> !out_err);
    // R6
    ins_order_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4 && in_hi_fld < in_lo_fld) |=> out_err);
    // R2
    ext_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0) |=> (out_err || out_data[63:32] == {32{out_data[31]}}));
    // R11
    full_width_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == 3'd2 || in_op == 3'd6) && in_hi_fld == 5'd31 && in_lo_fld == 5'd0)
        |=> out_data == $past(in_src));
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_err)));
endmodule

bind bfu_top bfu_chk u_chk (.*);

// File: tb/tb_bfu_top.sv
module tb_bfu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_hi_fld = '0;
    logic [4:0]  in_lo_fld = '0;
    logic [63:0] in_src = '0;
    logic [63:0] in_dst = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] exp_data[$];
    logic        exp_err[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    bfu_top dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench-side model, bit by bit from the requirements.
    task automatic model(input logic [2:0] op, input int a, input int b,
                         input logic [63:0] s, input logic [63:0] d,
                         output logic [63:0] r, output logic e);
        int lo, hi, lim;
        bit ext;
        ext = (op < 3'd4);
        lim = 64;
        case (op)
            3'd0: begin lo = b;      hi = b + a;      lim = 32; end
            3'd1: begin lo = b;      hi = b + a;      end
            3'd2: begin lo = b;      hi = b + a + 32; end
            3'd3: begin lo = b + 32; hi = lo + a;     end
            3'd4: begin lo = b;      hi = a;          lim = 32; end
            3'd5: begin lo = b;      hi = a;          end
            3'd6: begin lo = b;      hi = a + 32;     end
            default: begin lo = b + 32; hi = a + 32;  end
        endcase
        if (hi < lo || hi >= lim) begin
            r = d; e = 1'b1;
        end else begin
            e = 1'b0;
            if (ext) begin
                r = '0;
                for (int i = 0; i <= hi - lo; i++) r[i] = s[lo + i];
            end else begin
                r = d;
                for (int i = lo; i <= hi; i++) r[i] = s[i - lo];
            end
            if (lim == 32) for (int i = 32; i < 64; i++) r[i] = r[31];
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic e);
        if (e) return "R10";
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic issue_raw(input logic [2:0] op, input logic [4:0] a, input logic [4:0] b,
                             input logic [63:0] s, input logic [63:0] d,
                             input logic [63:0] r, input logic e, input string tag);
        exp_data.push_back(r);
        exp_err.push_back(e);
        exp_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_hi_fld = a; in_lo_fld = b; in_src = s; in_dst = d;
    endtask

    task automatic issue(input logic [2:0] op, input logic [4:0] a, input logic [4:0] b,
                         input logic [63:0] s, input logic [63:0] d, input string tag);
        logic [63:0] r;
        logic e;
        model(op, int'(a), int'(b), s, d, r, e);
        issue_raw(op, a, b, s, d, r, e, (tag == "") ? req_of(op, e) : tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: scoreboard pop and compare, 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (!rst && !done && out_valid) begin
            if (exp_data.size() == 0) begin
                chk(1'b0, "R1 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                logic [63:0] ed;
                logic        ee;
                string       et;
                ed = exp_data.pop_front();
                ee = exp_err.pop_front();
                et = exp_tag.pop_front();
                chk(out_data == ed, {et, " data"}, out_data, ed);
                chk(out_err == ee, {et, " err"}, 64'(out_err), 64'(ee));
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_data.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        logic        held_e;
        logic [63:0] s0, d0;
        // R1: valid during reset is dropped
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        chk(out_data == 64'd0, "R1 reset data", out_data, 64'd0);
        chk(out_err == 1'b0, "R1 reset err", 64'(out_err), 64'd0);

        // Hand-computed corner values
        issue_raw(3'd0, 5'd0, 5'd31, 64'h0000_0000_8000_0000, 64'd0, 64'd1, 1'b0, "R2 single bit");
        issue_raw(3'd4, 5'd31, 5'd31, 64'd1, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0, "R6 sign");
        issue_raw(3'd1, 5'd31, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_FFFF, 1'b0, "R3 no sext");
        issue_raw(3'd2, 5'd31, 5'd0, 64'hDEAD_BEEF_0123_4567, 64'd5, 64'hDEAD_BEEF_0123_4567, 1'b0, "R11 ext64");
        issue_raw(3'd6, 5'd31, 5'd0, 64'hCAFE_F00D_8888_1111, 64'd7, 64'hCAFE_F00D_8888_1111, 1'b0, "R11 ins64");
        issue_raw(3'd3, 5'd31, 5'd0, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'h1234_5678, 1'b0, "R5 upper word");
        issue_raw(3'd7, 5'd31, 5'd0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444,
                  64'hCCCC_DDDD_3333_4444, 1'b0, "R9 upper word");
        issue_raw(3'd5, 5'd3, 5'd9, 64'hFF, 64'h55, 64'h55, 1'b1, "R10 inverted");
        issue_raw(3'd0, 5'd4, 5'd30, 64'hFF, 64'h66, 64'h66, 1'b1, "R10 past 32");
        idle(1);

        // R12: outputs hold while idle even with other inputs moving
        @(posedge clk); #2;
        held = out_data; held_e = out_err;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_src = {$urandom, $urandom}; in_dst = {$urandom, $urandom};
            in_op = 3'($urandom); in_hi_fld = 5'($urandom); in_lo_fld = 5'($urandom);
        end
        chk(out_data == held, "R12 data hold", out_data, held);
        chk(out_err == held_e, "R12 err hold", 64'(out_err), 64'(held_e));

        // Every position pair for every variant, back to back
        for (int op = 0; op < 8; op++) begin
            s0 = {$urandom, $urandom} | 64'h8000_0000_8000_0000;
            d0 = {$urandom, $urandom};
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 32; b++)
                    issue(3'(op), 5'(a), 5'(b), s0, d0, "");
        end
        idle(2);

        // Random operands with gaps
        for (int i = 0; i < 3000; i++) begin
            issue(3'($urandom), 5'($urandom), 5'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom}, "");
            if (($urandom % 5) == 0) idle(1);
        end
        idle(3);
        chk(exp_data.size() == 0, "R1 all results returned", 64'(exp_data.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule